// File: doc/BRIEF.md
# Bidirectional Port with Serial-Link Direction Override

This block is an eight-pin general-purpose I/O port. Software sets each pin's direction through a direction register. A second register, the level register, serves two purposes: it gives the level driven on output pins, and it enables the weak pull-up on input pins. The block does not drive pads itself. It produces per-pin output-enable, output-level and pull-up-enable signals for an external pad model. Pin levels coming back from the pads pass through a synchronizer before they can be read.

Four pins are shared with an SPI peripheral. While the SPI is enabled, its role overrides the direction register on those pins:
- As a slave, the clock, the incoming data pin and the select pin are forced to inputs.
- As a master, only the returning data pin is forced to an input.

A forced pin keeps its pull-up under control of its level-register bit.

The block also has two outputs for other blocks. A pair of flags shows when the two comparator-capable pins are plain floating inputs. Two synchronized pin values are passed on as external count sources for timers.

Top module: `gpio_spi_port`

## Requirements
- R1: A write strobe loads the direction register or the level register on the clock edge where it is sampled. The contents appear on `dir_q` and `lvl_q` from the next cycle on. A clock edge with `rst` high clears both registers to 0.
- R2: With no override active, `pad_oe[n]` equals the direction bit of pin n. `pad_out[n]` equals the level bit when the pin is an output, and is 0 otherwise.
- R3: `pad_pu[n]` is 1 only when pin n is not driven (`pad_oe[n]`=0) and its level bit is 1.
- R4: While `rst` is high, `pad_oe` and `pad_pu` are all 0 at once, with no clock edge needed.
- R5: With `spi_en`=1 and `spi_master`=0 (slave), pins 7 (clock), 5 (data in) and 4 (select) are never driven. Pin 6 follows its direction bit.
- R6: With `spi_en`=1 and `spi_master`=1, pin 6 (data return) is never driven. Pins 7, 5 and 4 follow their direction bits.
- R7: A pin forced to input by R5 or R6 has `pad_pu` equal to its level bit.
- R8: With `spi_en`=0, `spi_master` has no effect on any pad output.
- R9: `cmp_neg_ok` is 1 exactly when the direction and level bits of pin 3 are both 0. `cmp_pos_ok` is the same for pin 2.
- R10: `pin_rd` equals the `pin_in` value sampled two clock edges earlier. After reset it reads 0 until non-reset samples arrive.
- R11: `tmr0_src` equals `pin_rd[0]` and `tmr1_src` equals `pin_rd[1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset: synchronous for the registers, immediate for the pad controls |
| dir_we | input | 1 | Direction register write strobe |
| dir_wdata | input | 8 | Direction write data (1 = output) |
| lvl_we | input | 1 | Level register write strobe |
| lvl_wdata | input | 8 | Level / pull-up write data |
| dir_q | output | 8 | Direction register contents |
| lvl_q | output | 8 | Level register contents |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_rd | output | 8 | Synchronized pin levels |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI role: 1 = master, 0 = slave |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven level |
| pad_pu | output | 8 | Per-pin pull-up enable |
| cmp_neg_ok | output | 1 | Pin 3 is free for the comparator's negative input |
| cmp_pos_ok | output | 1 | Pin 2 is free for the comparator's positive input |
| tmr0_src | output | 1 | Synchronized pin 0 count source |
| tmr1_src | output | 1 | Synchronized pin 1 count source |

## Verification
The bench builds the block with its default parameters:
- an eight-pin port;
- a two-stage synchronizer;
- the serial pins at positions 7, 6, 5 and 4.

These values give every pad output a fixed expected position, and the delay from `pin_in` to `pin_rd` is a fixed two edges. The reference model can therefore predict every output bit on every clock. The bench covers both SPI roles, the disabled state with the role input toggling, random register contents, a reset raised in the middle of a cycle, and pin changes on back-to-back cycles through the synchronizer.

// File: rtl/gpio_spi_pkg.sv
package gpio_spi_pkg;
  localparam int PORT_W_DEF   = 8;
  localparam int SYNC_DEF     = 2;
  localparam int POS_CLK_DEF  = 7;
  localparam int POS_RET_DEF  = 6;
  localparam int POS_DIN_DEF  = 5;
  localparam int POS_SEL_DEF  = 4;
  localparam int POS_CMPN_DEF = 3;
  localparam int POS_CMPP_DEF = 2;
  localparam int POS_TMR1_DEF = 1;
  localparam int POS_TMR0_DEF = 0;

  typedef enum logic {ROLE_SLAVE = 1'b0, ROLE_MASTER = 1'b1} spi_role_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_we,
  input  logic [W-1:0] dir_wdata,
  input  logic         lvl_we,
  input  logic [W-1:0] lvl_wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lvl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else begin
      if (dir_we) dir_q <= dir_wdata;
      if (lvl_we) lvl_q <= lvl_wdata;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_spi_override.sv
module gpio_spi_override
  import gpio_spi_pkg::*;
#(
  parameter int W       = 8,
  parameter int POS_CLK = 7,
  parameter int POS_RET = 6,
  parameter int POS_DIN = 5,
  parameter int POS_SEL = 4
) (
  input  logic         spi_en,
  input  logic         spi_master,
  output logic [W-1:0] force_in
);
  spi_role_e role;
  assign role = spi_role_e'(spi_master);

  always_comb begin
    force_in = '0;
    if (spi_en) begin
      if (role == ROLE_MASTER) begin
        force_in[POS_RET] = 1'b1;
      end else begin
        force_in[POS_CLK] = 1'b1;
        force_in[POS_DIN] = 1'b1;
        force_in[POS_SEL] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_spi_port.sv
module gpio_spi_port
  import gpio_spi_pkg::*;
#(
  parameter int W        = PORT_W_DEF,
  parameter int STAGES   = SYNC_DEF,
  parameter int POS_CLK  = POS_CLK_DEF,
  parameter int POS_RET  = POS_RET_DEF,
  parameter int POS_DIN  = POS_DIN_DEF,
  parameter int POS_SEL  = POS_SEL_DEF,
  parameter int POS_CMPN = POS_CMPN_DEF,
  parameter int POS_CMPP = POS_CMPP_DEF,
  parameter int POS_TMR1 = POS_TMR1_DEF,
  parameter int POS_TMR0 = POS_TMR0_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_we,
  input  logic [W-1:0] dir_wdata,
  input  logic         lvl_we,
  input  logic [W-1:0] lvl_wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lvl_q,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_rd,
  input  logic         spi_en,
  input  logic         spi_master,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu,
  output logic         cmp_neg_ok,
  output logic         cmp_pos_ok,
  output logic         tmr0_src,
  output logic         tmr1_src
);
  logic [W-1:0] force_in;
  logic [W-1:0] rst_mask;

  gpio_port_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst),
    .dir_we(dir_we), .dir_wdata(dir_wdata),
    .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
    .dir_q(dir_q), .lvl_q(lvl_q)
  );

  gpio_in_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_rd)
  );

  gpio_spi_override #(
    .W(W), .POS_CLK(POS_CLK), .POS_RET(POS_RET),
    .POS_DIN(POS_DIN), .POS_SEL(POS_SEL)
  ) u_ovr (
    .spi_en(spi_en), .spi_master(spi_master), .force_in(force_in)
  );

  // reset releases the pads at once, independent of the clock
  assign rst_mask = {W{~rst}};

  generate
    for (genvar n = 0; n < W; n++) begin : g_pad
      assign pad_oe[n]  = rst_mask[n] & dir_q[n] & ~force_in[n];
      assign pad_out[n] = pad_oe[n] & lvl_q[n];
      assign pad_pu[n]  = rst_mask[n] & ~pad_oe[n] & lvl_q[n];
    end
  endgenerate

  assign cmp_neg_ok = ~dir_q[POS_CMPN] & ~lvl_q[POS_CMPN];
  assign cmp_pos_ok = ~dir_q[POS_CMPP] & ~lvl_q[POS_CMPP];
  assign tmr0_src   = pin_rd[POS_TMR0];
  assign tmr1_src   = pin_rd[POS_TMR1];
endmodule

// File: rtl/gpio_spi_port_chk.sv
module gpio_spi_port_chk #(
  parameter int W       = 8,
  parameter int STAGES  = 2,
  parameter int POS_CLK = 7,
  parameter int POS_RET = 6,
  parameter int POS_DIN = 5,
  parameter int POS_SEL = 4,
  parameter int POS_CMPN = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         dir_we,
  input logic [W-1:0] dir_wdata,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] pin_in,
  input logic [W-1:0] pin_rd,
  input logic         spi_en,
  input logic         spi_master,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_pu,
  input logic         cmp_neg_ok
);
  logic [1:0] live;
  always_ff @(posedge clk) begin
    if (rst)            live <= 2'd0;
    else if (live != 2'd2) live <= live + 2'd1;
  end

  // R1
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (live != 2'd0 && $past(dir_we)) |-> dir_q == $past(dir_wdata));

  // R3
  pullup_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_oe) == '0);

  // R4
  always @(negedge clk) begin
    if (rst) begin
      oe_in_reset_chk: assert (pad_oe == '0 && pad_pu == '0);
    end
  end

  // R5
  slave_force_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_en && !spi_master) |->
      (!pad_oe[POS_CLK] && !pad_oe[POS_DIN] && !pad_oe[POS_SEL]));

  // R6
  master_force_chk: assert property (@(posedge clk) disable iff (rst)
    (spi_en && spi_master) |-> !pad_oe[POS_RET]);

  // R9
  cmp_free_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_neg_ok |-> (!pad_oe[POS_CMPN] && !pad_pu[POS_CMPN]));

  generate
    if (STAGES == 2) begin : g_sync2
      // R10
      sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (live == 2'd2) |-> pin_rd == $past(pin_in, 2));
    end
  endgenerate
endmodule

bind gpio_spi_port gpio_spi_port_chk #(
  .W(W), .STAGES(STAGES), .POS_CLK(POS_CLK), .POS_RET(POS_RET),
  .POS_DIN(POS_DIN), .POS_SEL(POS_SEL), .POS_CMPN(POS_CMPN)
) u_chk (
  .clk(clk), .rst(rst), .dir_we(dir_we), .dir_wdata(dir_wdata),
  .dir_q(dir_q), .pin_in(pin_in), .pin_rd(pin_rd), .spi_en(spi_en),
  .spi_master(spi_master), .pad_oe(pad_oe), .pad_pu(pad_pu),
  .cmp_neg_ok(cmp_neg_ok)
);

// File: tb/gpio_spi_port_test.sv
`timescale 1ns/1ps
module gpio_spi_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dir_we = 1'b0, lvl_we = 1'b0;
  logic [7:0] dir_wdata = '0, lvl_wdata = '0;
  logic [7:0] dir_q, lvl_q, pin_in = '0, pin_rd;
  logic       spi_en = 1'b0, spi_master = 1'b0;
  logic [7:0] pad_oe, pad_out, pad_pu;
  logic       cmp_neg_ok, cmp_pos_ok, tmr0_src, tmr1_src;

  int n_chk = 0;
  int n_bad = 0;

  gpio_spi_port uut (
    .clk(clk), .rst(rst), .dir_we(dir_we), .dir_wdata(dir_wdata),
    .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .dir_q(dir_q), .lvl_q(lvl_q),
    .pin_in(pin_in), .pin_rd(pin_rd), .spi_en(spi_en), .spi_master(spi_master),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
    .cmp_neg_ok(cmp_neg_ok), .cmp_pos_ok(cmp_pos_ok),
    .tmr0_src(tmr0_src), .tmr1_src(tmr1_src)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference state
  logic [7:0] m_dir = '0, m_lvl = '0;
  logic [7:0] m_q[$] = '{8'h00, 8'h00};
  bit         m_valid = 0;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_force();
    logic [7:0] f = '0;
    if (spi_en) begin
      if (spi_master) f[6] = 1'b1;
      else begin f[7] = 1'b1; f[5] = 1'b1; f[4] = 1'b1; end
    end
    return f;
  endfunction

  task automatic compare_all();
    logic [7:0] f, oe, pu;
    string otag, ptag;
    f  = exp_force();
    oe = rst ? 8'h00 : (m_dir & ~f);
    pu = rst ? 8'h00 : (m_lvl & ~oe);
    otag = !spi_en ? "R2 R8" : (spi_master ? "R6" : "R5");
    ptag = (f != 0) ? "R3 R7" : "R3";
    check(dir_q, m_dir, "R1 dir");
    check(lvl_q, m_lvl, "R1 lvl");
    check(pad_oe, oe, otag);
    check(pad_out, oe & m_lvl, "R2 out");
    check(pad_pu, pu, ptag);
    check({6'd0, cmp_neg_ok, cmp_pos_ok},
          {6'd0, ~m_dir[3] & ~m_lvl[3], ~m_dir[2] & ~m_lvl[2]}, "R9");
    check(pin_rd, m_q[0], "R10");
    check({6'd0, tmr1_src, tmr0_src}, {6'd0, m_q[0][1], m_q[0][0]}, "R11");
  endtask

  // model advances on each edge, comparison a quarter period later
  always @(posedge clk) begin
    if (rst) begin
      m_dir = '0; m_lvl = '0; m_q = '{8'h00, 8'h00}; m_valid = 1;
    end else if (m_valid) begin
      if (dir_we) m_dir = dir_wdata;
      if (lvl_we) m_lvl = lvl_wdata;
      m_q.push_back(pin_in);
      void'(m_q.pop_front());
    end
    #(CLK_PERIOD/4);
    if (m_valid) compare_all();
  end

  task automatic step(input logic dwe, input logic [7:0] dw, input logic lwe,
                      input logic [7:0] lw, input logic [7:0] pins,
                      input logic en, input logic mst);
    @(negedge clk);
    dir_we = dwe; dir_wdata = dw; lvl_we = lwe; lvl_wdata = lw;
    pin_in = pins; spi_en = en; spi_master = mst;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    // R1 reset state held over a few edges
    repeat (3) step(1'b1, 8'hFF, 1'b1, 8'hFF, 8'hA5, 1'b0, 1'b0);
    rst = 1'b0;
    step(0, 0, 0, 0, 8'h00, 0, 0);
    // R2 R3 plain port: four direction/level combos per pin pair
    step(1, 8'hCC, 1, 8'hAA, 8'h3C, 0, 0);
    step(0, 0, 0, 0, 8'hC3, 0, 1);          // R8 role toggled while disabled
    step(0, 0, 0, 0, 8'hFF, 0, 0);
    // R9 free comparator pins, then occupied
    step(1, 8'h00, 1, 8'h00, 8'h01, 0, 0);
    step(1, 8'h04, 1, 8'h08, 8'h02, 0, 0);
    // R5 slave: all outputs requested, pull-ups on
    step(1, 8'hFF, 1, 8'hFF, 8'h55, 1, 0);
    step(0, 0, 1, 8'h0F, 8'hAA, 1, 0);
    // R6 master
    step(0, 0, 1, 8'hFF, 8'h00, 1, 1);
    step(1, 8'h0F, 0, 0, 8'hFF, 1, 1);      // R7 forced pin 6 pull-up
    // R10 R11 back-to-back pin changes
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 8'(1 << i) | 8'(i), 0, 0);
    // random sweep across roles and registers
    for (int i = 0; i < 400; i++)
      step(1'($urandom), 8'($urandom), 1'($urandom), 8'($urandom),
           8'($urandom), 1'($urandom), 1'($urandom));
    // R4 reset raised mid-cycle: pads released before any edge
    step(1, 8'hF0, 1, 8'hFF, 8'h00, 0, 0);
    step(0, 0, 0, 0, 8'h00, 0, 0);
    @(negedge clk);
    #1 rst = 1'b1;
    #1;
    check(pad_oe, 8'h00, "R4 oe");
    check(pad_pu, 8'h00, "R4 pu");
    step(0, 0, 0, 0, 8'h00, 0, 0);
    rst = 1'b0;
    repeat (4) step(0, 0, 0, 0, 8'h5A, 0, 0);
    finish_run();
  end
endmodule